// File: doc/BRIEF.md
# Dual-Mode Slow Debug Clock Generator

This block derives a slow, human-observable clock from a fast system clock, for stepping through sequential logic while it is debugged. A mode switch chooses between two behaviours. With the switch at 1 the slow clock runs freely with a 50% duty cycle. With the switch at 0 the slow clock rests low, and every clean press of a push button produces exactly one high pulse. That pulse is as wide as the high phase of the free-running clock.

The button and the mode switch are asynchronous to the system clock. Both pass through two-flop synchronizers, and the button is also debounced. Every high pulse runs to its full width and is always followed by a full-width low phase, whatever the switch does in the meantime. As a result, a mode change never produces a runt high pulse or two high phases merged into one. A status LED output shows the mode switch directly.

The half period is computed as `SYS_CLK_HZ / (2 * SLOW_CLK_HZ)` system cycles. Defaults give roughly 1.537 kHz (650 us period) from 50 MHz, and simulation can use small values.

Top module: `lcg_clkgen`

## Requirements
- R1: With the mode switch at 1, `slow_clk` toggles with a period of exactly 2*H system cycles, where H = floor(SYS_CLK_HZ / (2*SLOW_CLK_HZ)). It is high for H cycles and low for H cycles. Leaving the idle state starts with a high phase.
- R2: With the mode switch at 0 and no pulse in progress, `slow_clk` stays low. Each debounced rising edge of the button starts exactly one high pulse.
- R3: Every high phase of `slow_clk` in either mode lasts exactly H cycles. Every low phase after the first high phase lasts at least H cycles.
- R4: `mode_led` equals `mode_sw` at all times, combinationally.
- R5: The button is synchronized by two flops. Its debounced level changes only after the synchronized level has differed from it for DEBOUNCE_CYCLES consecutive cycles. A press held for DEBOUNCE_CYCLES-1 cycles or shorter, and any bouncing shorter than that, produces no pulse.
- R6: A debounced press that arrives while a pulse or its trailing low phase is in progress is ignored. A button held down for a long time yields only one pulse.
- R7: When the mode switch changes while `slow_clk` is high, the high phase still completes its full H cycles. After a change to 0, the output then stays low until the next press.
- R8: The synchronous, active-high reset `rst` forces `slow_clk` low at the next clock edge and clears the phase counter, the synchronizers and the debounce state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sw | input | 1 | Mode switch: 1 = continuous, 0 = single-step (asynchronous) |
| step_btn | input | 1 | Single-step push button, active high, may bounce (asynchronous) |
| slow_clk | output | 1 | Generated slow clock |
| mode_led | output | 1 | Mirror of mode_sw |

## Verification
The continuous mode is tried with the switch held at 1. Counting rising edges over a fixed window separates a correct 2*H period from an off-by-one divider. Single clean presses, presses held exactly one cycle short of and exactly equal to the debounce length, and trains of short bounces separate a working debouncer from one that fires early or not at all. A second press during the trailing low phase and a long hold show whether busy-time presses are dropped. Mode flips in the middle of a high phase, resets in the middle of a pulse, and a seeded random mix of switch and button activity are run under a monitor of run lengths that requires every high run to be exactly H and every later low run to be at least H.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // system cycles per half period of the slow clock, never below 2
  function automatic int unsigned half_cycles(input int unsigned sys_hz,
                                              input int unsigned slow_hz);
    int unsigned h;
    h = sys_hz / (2 * slow_hz);
    return (h < 2) ? 2 : h;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/lcg_sync.sv
module lcg_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/lcg_debounce.sv
module lcg_debounce
  import lcg_pkg::*;
#(
  parameter int unsigned STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam int unsigned DW = cnt_width(STABLE);

  logic [DW-1:0] cnt_q;
  logic          differs;
  logic          settle;

  assign differs = (lvl_i != lvl_o);
  assign settle  = differs && (cnt_q == DW'(STABLE - 1));
  assign rise_o  = settle && lvl_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (settle) begin
      cnt_q <= '0;
      lvl_o <= lvl_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the counter never passes its terminal value
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DW'(STABLE - 1));

  // R5: a rising event only follows a level held high on consecutive cycles
  p_rise_stable_r5: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (lvl_i && $past(lvl_i) && !lvl_o));

endmodule

// File: rtl/lcg_clkgen.sv
module lcg_clkgen
  import lcg_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ      = 50_000_000,
  parameter int unsigned SLOW_CLK_HZ     = 1537,
  parameter int unsigned DEBOUNCE_CYCLES = 250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sw,
  input  logic step_btn,
  output logic slow_clk,
  output logic mode_led
);
  localparam int unsigned HALF = half_cycles(SYS_CLK_HZ, SLOW_CLK_HZ);
  localparam int unsigned CW   = cnt_width(HALF);

  logic [1:0]    raw_in;
  logic [1:0]    synced;
  logic          mode_s;
  logic          btn_s;
  logic          btn_lvl;
  logic          step_evt;
  logic          phase_end;
  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q;

  assign mode_led = mode_sw;

  assign raw_in = {mode_sw, step_btn};

  lcg_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_in),
    .sync_o  (synced)
  );

  assign mode_s = synced[1];
  assign btn_s  = synced[0];

  lcg_debounce #(.STABLE(DEBOUNCE_CYCLES)) u_deb (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (btn_s),
    .lvl_o  (btn_lvl),
    .rise_o (step_evt)
  );

  assign phase_end = (cnt_q == CW'(HALF - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (mode_s || step_evt) state_d = PH_HIGH;
      PH_HIGH: if (phase_end) state_d = PH_LOW;
      PH_LOW:  if (phase_end) state_d = mode_s ? PH_HIGH : PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      slow_clk <= 1'b0;
    end else begin
      state_q  <= state_d;
      slow_clk <= (state_d == PH_HIGH);
      if (state_d != state_q || state_q == PH_IDLE) cnt_q <= '0;
      else                                         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: reset drives the output low at the next edge
  p_rst_low_r8: assert property (@(posedge clk)
    rst |=> !slow_clk);

  // R3/R7: a high phase ends only after its full count
  p_full_high_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(slow_clk) && !$past(rst)) |-> ($past(cnt_q) == CW'(HALF - 1)));

  // R1: continuous mode leaves idle with a high phase
  p_cont_start_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_IDLE && mode_s) |=> slow_clk);

  // R2: a debounced press in idle starts a pulse
  p_step_start_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_IDLE && step_evt) |=> slow_clk);

  // R6: the trailing low phase is not cut short by a press
  p_busy_low_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_LOW && !phase_end) |=> !slow_clk);

  // R4: the LED tracks the switch
  always_comb begin
    a_led_r4: assert (mode_led === mode_sw);
  end

  logic unused_lvl;
  assign unused_lvl = btn_lvl;

endmodule

// File: tb/sim_lcg_clkgen.sv
module sim_lcg_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 1000;
  localparam int SLOW_HZ    = 50;
  localparam int DEB        = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sw = 1'b0;
  logic step_btn = 1'b0;
  logic slow_clk;
  logic mode_led;

  int checks = 0;
  int failures = 0;
  int rises = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcg_clkgen #(
    .SYS_CLK_HZ(SYS_HZ), .SLOW_CLK_HZ(SLOW_HZ), .DEBOUNCE_CYCLES(DEB)
  ) u0 (
    .clk(clk), .rst(rst), .mode_sw(mode_sw), .step_btn(step_btn),
    .slow_clk(slow_clk), .mode_led(mode_led)
  );

  // half period by repeated subtraction of the full-period rate
  function automatic int bench_half(input int sys_hz, input int slow_hz);
    int rem = sys_hz;
    int n = 0;
    while (rem >= 2 * slow_hz) begin
      rem -= 2 * slow_hz;
      n++;
    end
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int rises_in(input int cycles, input int h);
    return cycles / (2 * h);
  endfunction

  localparam int H = bench_half(SYS_HZ, SLOW_HZ);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run-length monitor: every high run is H, later low runs at least H
  logic prev = 1'b0;
  int   run = 0;
  bit   seen_high = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      run <= 0;
      seen_high <= 1'b0;
    end else if (slow_clk !== prev) begin
      if (prev) begin
        check("R3 high run length", run, H);
        seen_high <= 1'b1;
      end else if (seen_high) begin
        check("R3 low run at least H", (run >= H) ? 1 : 0, 1);
      end
      if (slow_clk) rises <= rises + 1;
      prev <= slow_clk;
      run <= 1;
    end else begin
      run <= run + 1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic press(input int hold, input int rel);
    step_btn = 1'b1;
    cyc(hold);
    step_btn = 1'b0;
    cyc(rel);
  endtask

  task automatic wait_rise();
    int r0 = rises;
    int guard = 0;
    while (rises == r0 && guard < 10 * H) begin
      cyc(1);
      guard++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0;
    int dummy;
    dummy = $urandom(32'h5eed);
    cyc(3);
    check("R8 reset output low", slow_clk, 0);
    rst = 1'b0;
    cyc(2 * H);
    check("R2 idle stays low", slow_clk, 0);
    check("R2 no rise idle", rises, 0);

    // R4 LED mirror
    mode_sw = 1'b1; #2;
    check("R4 led follows 1", mode_led, 1);
    mode_sw = 1'b0; #2;
    check("R4 led follows 0", mode_led, 0);
    cyc(1);

    // R2 single clean press
    r0 = rises;
    press(DEB + 6, 3 * H);
    check("R2 one pulse per press", rises - r0, 1);
    check("R2 low after pulse", slow_clk, 0);

    // R5 boundary: DEB-1 high gives nothing, DEB gives one
    r0 = rises;
    press(DEB - 1, 3 * H);
    check("R5 short press ignored", rises - r0, 0);
    r0 = rises;
    press(DEB, 3 * H);
    check("R5 press of DEB cycles accepted", rises - r0, 1);

    // R5 bounce train
    r0 = rises;
    for (int i = 0; i < 6; i++) press(1 + (i % 2), 2);
    cyc(3 * H);
    check("R5 bounce ignored", rises - r0, 0);

    // R6 second press during trailing low, then a long hold
    r0 = rises;
    press(8, 6);
    press(8, 3 * H);
    check("R6 press while busy ignored", rises - r0, 1);
    r0 = rises;
    press(5 * H, 3 * H);
    check("R6 long hold one pulse", rises - r0, 1);

    // R1 continuous period
    mode_sw = 1'b1;
    wait_rise();
    r0 = rises;
    cyc(8 * H + 1);
    check("R1 rises over 4 periods", rises - r0, rises_in(8 * H + 1, H));
    r0 = rises;
    cyc(2 * H * 5 + 1);
    check("R1 rises over 5 periods", rises - r0, 5);

    // R7 mode drop mid high
    wait_rise();
    cyc(2);
    mode_sw = 1'b0;
    cyc(4 * H);
    r0 = rises;
    check("R7 low after mode drop", slow_clk, 0);
    cyc(3 * H);
    check("R7 stays low after drop", rises - r0, 0);

    // R7 switch to continuous right after a step pulse
    press(DEB + 4, 0);
    mode_sw = 1'b1;
    cyc(6 * H);
    mode_sw = 1'b0;
    cyc(4 * H);

    // R8 reset in the middle of a pulse
    press(DEB + 3, 0);
    wait_rise();
    cyc(2);
    rst = 1'b1;
    cyc(1);
    check("R8 reset forces low", slow_clk, 0);
    cyc(2);
    rst = 1'b0;
    cyc(3 * H);
    check("R8 low after reset", slow_clk, 0);

    // random mix, checked by the run-length monitor (R3, R7)
    for (int i = 0; i < 60; i++) begin
      if ($urandom % 4 == 0) mode_sw = ~mode_sw;
      press(1 + ($urandom % (3 * DEB)), 1 + ($urandom % (2 * H)));
    end
    mode_sw = 1'b0;
    cyc(5 * H);
    check("R2 random mix ends low", slow_clk, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule